// File: doc/BRIEF.md
# Floating-Point to Signed Integer Converter

This block turns an IEEE single- or double-precision operand into a signed 32-bit or 64-bit integer. It is built for the convert path of a floating-point unit. The operand arrives with a valid strobe and with selects for source precision and destination width. The result, an invalid flag and an inexact flag come out exactly two clock cycles later with their own valid strobe. A new operand may be accepted on every cycle.

The rounding rule comes from one of two places. The global rounding-mode control field supplies it for the generic convert operation. An explicit per-operation override supplies it for the round, truncate, ceiling and floor variants, and in that case the control field is ignored. Both use the same 2-bit code: 0 round to nearest with ties to even, 1 toward zero, 2 toward +infinity, 3 toward −infinity.

A single-precision operand sits in bits 31:0 of the operand bus. A 32-bit result is returned sign-extended across all 64 output bits.

Top module: `fp2int_cvt`

## Requirements
- R1: `out_valid` is high in exactly the cycles that come two clock edges after a cycle with `in_valid` high. Each accepted operand produces one result. Back-to-back operands are allowed.
- R2: With mode code 0, the result is the nearest integer. An exact tie (fraction exactly one half) goes to the even integer.
- R3: With mode code 1, the fraction is discarded, so the result moves toward zero.
- R4: Mode code 2 rounds toward +infinity and mode code 3 rounds toward −infinity. This holds for both signs and for operands of magnitude below one.
- R5: When `in_rm_explicit` is 1, `in_rm_sel` decides the rounding and `ctrl_rm` has no effect. When it is 0, `ctrl_rm` decides.
- R6: A NaN or infinity operand sets `out_invalid` and returns the largest positive integer of the destination width. That is 0x7FFFFFFF for a word and 0x7FFFFFFFFFFFFFFF for a long.
- R7: A rounded result outside the destination's signed range sets `out_invalid` and returns the same largest positive integer. The most negative value (−2^31 or −2^63) is a valid result.
- R8: `out_inexact` is set when the rounded result differs from the operand, and only when `out_invalid` is clear. Zero operands give 0 with no flags.
- R9: `in_src_dbl` = 1 reads bits 63:0 as a double (sign bit 63, 11-bit exponent, 52-bit fraction). `in_src_dbl` = 0 reads bits 31:0 as a single (sign bit 31, 8-bit exponent, 23-bit fraction). Subnormal operands are converted as nonzero values of magnitude below one.
- R10: With `in_dst_long` = 0, the 32-bit result is sign-extended into bits 63:32 of `out_int`.
- R11: While reset is asserted and after its release with no operand issued, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 64 | Floating-point operand bits |
| in_src_dbl | input | 1 | 1 = double source, 0 = single source |
| in_dst_long | input | 1 | 1 = 64-bit result, 0 = 32-bit result |
| in_rm_explicit | input | 1 | 1 = use `in_rm_sel`, 0 = use `ctrl_rm` |
| in_rm_sel | input | 2 | Explicit rounding code |
| ctrl_rm | input | 2 | Global rounding-mode control field |
| out_valid | output | 1 | Result strobe |
| out_int | output | 64 | Signed integer result |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The hardest cases to reach from the ports sit at range edges. One is an operand that lands exactly on the most negative integer, which must be accepted. Another is one that rounds up across the positive limit, which must be refused. A third is an exact half-way fraction under ties-to-even. Uniform random bit patterns almost never produce these. The stimulus therefore places their bit patterns directly, for both widths and both precisions. It also draws random operands whose exponent is confined to a window near the integer limits. In that window, overflow, tiny fractions and ties appear often under every rounding code and with the explicit and global sources mixed.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  localparam int OP_W    = 64;
  localparam int INT_W   = 64;
  localparam int WORD_W  = 32;
  localparam int MANT_W  = 53;
  localparam int EXP_W   = 13;
  localparam int MAG_W   = INT_W + 1;
  localparam int FRAC_W  = 64;
  localparam int ALIGN_W = MAG_W + FRAC_W + 1;

  typedef enum logic [1:0] {
    RM_NEAR = 2'd0,
    RM_ZERO = 2'd1,
    RM_UP   = 2'd2,
    RM_DOWN = 2'd3
  } rmode_e;

  typedef struct packed {
    logic             sign;
    logic             special;
    logic             huge;
    logic [MAG_W-1:0] mag;
    logic             rnd;
    logic             sticky;
    logic             lng;
    rmode_e           mode;
  } stage1_t;
endpackage

// File: rtl/fpcvt_unpack.sv
module fpcvt_unpack
  import fpcvt_pkg::*;
(
  input  logic                    op_dbl,
  input  logic [OP_W-1:0]         op,
  output logic                    sign,
  output logic                    special,
  output logic                    zero,
  output logic                    tiny,
  output logic signed [EXP_W-1:0] exp_unb,
  output logic [MANT_W-1:0]       mant
);
  logic [10:0] d_exp;
  logic [7:0]  s_exp;

  always_comb begin
    d_exp = op[62:52];
    s_exp = op[30:23];
    if (op_dbl) begin
      sign    = op[63];
      special = &d_exp;
      zero    = (d_exp == '0) && (op[51:0] == '0);
      tiny    = (d_exp == '0) && (op[51:0] != '0);
      exp_unb = $signed({2'b00, d_exp}) - 13'sd1023;
      mant    = {1'b1, op[51:0]};
    end else begin
      sign    = op[31];
      special = &s_exp;
      zero    = (s_exp == '0) && (op[22:0] == '0);
      tiny    = (s_exp == '0) && (op[22:0] != '0);
      exp_unb = $signed({5'b00000, s_exp}) - 13'sd127;
      mant    = {1'b1, op[22:0], 29'b0};
    end
  end
endmodule

// File: rtl/fpcvt_align.sv
module fpcvt_align
  import fpcvt_pkg::*;
(
  input  logic                    zero,
  input  logic                    tiny,
  input  logic signed [EXP_W-1:0] exp_unb,
  input  logic [MANT_W-1:0]       mant,
  output logic [MAG_W-1:0]        mag,
  output logic                    rnd,
  output logic                    sticky,
  output logic                    huge
);
  localparam int PT_OFS = FRAC_W - (MANT_W - 1);
  localparam int MAX_E  = MAG_W - 1;

  logic [ALIGN_W-1:0] wide;
  logic [EXP_W-1:0]   shv;

  always_comb begin
    shv  = exp_unb + EXP_W'(PT_OFS);
    wide = {{(ALIGN_W-MANT_W){1'b0}}, mant} << shv[6:0];
    mag    = '0;
    rnd    = 1'b0;
    sticky = 1'b0;
    huge   = 1'b0;
    if (zero) begin
      sticky = 1'b0;
    end else if (tiny || exp_unb < -13'sd1) begin
      sticky = 1'b1;
    end else if (exp_unb > EXP_W'(MAX_E)) begin
      huge = 1'b1;
    end else begin
      mag    = wide[ALIGN_W-2:FRAC_W];
      rnd    = wide[FRAC_W-1];
      sticky = |wide[FRAC_W-2:0];
    end
  end
endmodule

// File: rtl/fpcvt_round.sv
module fpcvt_round
  import fpcvt_pkg::*;
(
  input  stage1_t          s1,
  output logic [INT_W-1:0] res,
  output logic             inv,
  output logic             inx
);
  logic             inc;
  logic [MAG_W:0]   mag_r;
  logic [MAG_W:0]   lim_pos;
  logic             ovf;
  logic [INT_W-1:0] signed_v;

  always_comb begin
    unique case (s1.mode)
      RM_NEAR: inc = s1.rnd & (s1.sticky | s1.mag[0]);
      RM_ZERO: inc = 1'b0;
      RM_UP:   inc = ~s1.sign & (s1.rnd | s1.sticky);
      default: inc = s1.sign & (s1.rnd | s1.sticky);
    endcase
    mag_r   = {1'b0, s1.mag} + {{MAG_W{1'b0}}, inc};
    lim_pos = s1.lng ? {{(MAG_W-INT_W+2){1'b0}}, {(INT_W-1){1'b1}}}
                     : {{(MAG_W-WORD_W+2){1'b0}}, {(WORD_W-1){1'b1}}};
    ovf     = s1.sign ? (mag_r > lim_pos + 1'b1) : (mag_r > lim_pos);
    inv     = s1.special | s1.huge | ovf;
    signed_v = s1.sign ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];
    if (inv) begin
      res = lim_pos[INT_W-1:0];
      inx = 1'b0;
    end else begin
      res = s1.lng ? signed_v
                   : {{(INT_W-WORD_W){signed_v[WORD_W-1]}}, signed_v[WORD_W-1:0]};
      inx = s1.rnd | s1.sticky;
    end
  end
endmodule

// File: rtl/fp2int_cvt.sv
module fp2int_cvt
  import fpcvt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OP_W-1:0]  in_op,
  input  logic             in_src_dbl,
  input  logic             in_dst_long,
  input  logic             in_rm_explicit,
  input  logic [1:0]       in_rm_sel,
  input  logic [1:0]       ctrl_rm,
  output logic             out_valid,
  output logic [INT_W-1:0] out_int,
  output logic             out_invalid,
  output logic             out_inexact
);
  logic                    u_sign, u_special, u_zero, u_tiny;
  logic signed [EXP_W-1:0] u_exp;
  logic [MANT_W-1:0]       u_mant;
  logic [MAG_W-1:0]        a_mag;
  logic                    a_rnd, a_sticky, a_huge;
  stage1_t                 s1_d, s1_q;
  logic                    v1_q;
  logic [INT_W-1:0]        r_res, res_q;
  logic                    r_inv, r_inx, inv_q, inx_q, lng_q;

  fpcvt_unpack u_unpack (
    .op_dbl(in_src_dbl), .op(in_op), .sign(u_sign), .special(u_special),
    .zero(u_zero), .tiny(u_tiny), .exp_unb(u_exp), .mant(u_mant)
  );

  fpcvt_align u_align (
    .zero(u_zero), .tiny(u_tiny), .exp_unb(u_exp), .mant(u_mant),
    .mag(a_mag), .rnd(a_rnd), .sticky(a_sticky), .huge(a_huge)
  );

  always_comb begin
    s1_d.sign    = u_sign;
    s1_d.special = u_special;
    s1_d.huge    = a_huge;
    s1_d.mag     = a_mag;
    s1_d.rnd     = a_rnd;
    s1_d.sticky  = a_sticky;
    s1_d.lng     = in_dst_long;
    s1_d.mode    = rmode_e'(in_rm_explicit ? in_rm_sel : ctrl_rm);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      s1_q <= '0;
    end else begin
      v1_q <= in_valid;
      if (in_valid) s1_q <= s1_d;
    end
  end

  fpcvt_round u_round (.s1(s1_q), .res(r_res), .inv(r_inv), .inx(r_inx));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      inv_q     <= 1'b0;
      inx_q     <= 1'b0;
      lng_q     <= 1'b0;
    end else begin
      out_valid <= v1_q;
      if (v1_q) begin
        res_q <= r_res;
        inv_q <= r_inv;
        inx_q <= r_inx;
        lng_q <= s1_q.lng;
      end
    end
  end

  assign out_int     = res_q;
  assign out_invalid = inv_q;
  assign out_inexact = inx_q;

  // R1
  latency_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 2));
  // R6
  sat_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |->
      out_int == (lng_q ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF));
  // R8
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_inexact));
  // R10
  word_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !lng_q) |-> out_int[63:32] == {32{out_int[31]}});
  // R11
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!in_valid) && $past(!v1_q) |-> !out_valid);
endmodule

// File: tb/tb_fp2int_cvt.sv
module tb_fp2int_cvt;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_src_dbl, in_dst_long, in_rm_explicit;
  logic [63:0] in_op;
  logic [1:0]  in_rm_sel, ctrl_rm;
  logic        out_valid, out_invalid, out_inexact;
  logic [63:0] out_int;
  int          errors = 0;
  int          checks = 0;
  bit          done = 0;

  always #4 clk = ~clk;

  fp2int_cvt dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_src_dbl(in_src_dbl), .in_dst_long(in_dst_long),
    .in_rm_explicit(in_rm_explicit), .in_rm_sel(in_rm_sel), .ctrl_rm(ctrl_rm),
    .out_valid(out_valid), .out_int(out_int),
    .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic check(string req, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic void ref_cvt(input logic [63:0] op, input bit dbl,
                                  input bit lng, input logic [1:0] mode,
                                  output logic [63:0] res, output bit inv,
                                  output bit inx);
    bit s, spec, zer, tny;
    int e;
    logic [127:0] m, ip, fr, half, mag, lim;
    int cmpc;
    bit inc;
    lim = lng ? 128'h7FFF_FFFF_FFFF_FFFF : 128'h7FFF_FFFF;
    if (dbl) begin
      s = op[63]; spec = (op[62:52] == 11'h7FF);
      zer = (op[62:0] == 0); tny = (op[62:52] == 0) && !zer;
      e = int'(op[62:52]) - 1023; m = {75'b0, 1'b1, op[51:0]};
    end else begin
      s = op[31]; spec = (op[30:23] == 8'hFF);
      zer = (op[30:0] == 0); tny = (op[30:23] == 0) && !zer;
      e = int'(op[30:23]) - 127; m = {75'b0, 1'b1, op[22:0], 29'b0};
    end
    inv = 0; inx = 0; res = 0;
    if (spec || (!zer && !tny && e >= 64)) begin
      inv = 1; res = lim[63:0]; return;
    end
    if (zer) return;
    cmpc = 0;
    if (tny || e < -1) begin ip = 0; cmpc = 1; end
    else if (e >= 52) begin ip = m << (e - 52); end
    else begin
      ip = m >> (52 - e);
      fr = m & ((128'd1 << (52 - e)) - 1);
      half = 128'd1 << (51 - e);
      if (fr == 0) cmpc = 0;
      else if (fr < half) cmpc = 1;
      else if (fr == half) cmpc = 2;
      else cmpc = 3;
    end
    case (mode)
      2'd0: inc = (cmpc == 3) || (cmpc == 2 && ip[0]);
      2'd1: inc = 0;
      2'd2: inc = !s && cmpc != 0;
      default: inc = s && cmpc != 0;
    endcase
    mag = ip + 128'(inc);
    if ((!s && mag > lim) || (s && mag > lim + 1)) begin
      inv = 1; res = lim[63:0]; return;
    end
    inx = (cmpc != 0);
    res = s ? (~mag[63:0] + 64'd1) : mag[63:0];
    if (!lng) res = {{32{res[31]}}, res[31:0]};
  endfunction

  task automatic run(string req, logic [63:0] op, bit dbl, bit lng, bit expl,
                     logic [1:0] sel, logic [1:0] ctl);
    logic [63:0] er; bit ei, ex;
    ref_cvt(op, dbl, lng, expl ? sel : ctl, er, ei, ex);
    in_op = op; in_src_dbl = dbl; in_dst_long = lng;
    in_rm_explicit = expl; in_rm_sel = sel; ctrl_rm = ctl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R1 early"}, {65'b0, out_valid}, 66'd0);
    @(negedge clk);
    check({req, " R1 valid"}, {65'b0, out_valid}, 66'd1);
    check(req, {out_invalid, out_inexact, out_int}, {ei, ex, er});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 1'b0; in_valid = 0; in_op = 0; in_src_dbl = 0; in_dst_long = 0;
    in_rm_explicit = 0; in_rm_sel = 0; ctrl_rm = 0;
    repeat (3) @(negedge clk);
    check("R11 reset", {65'b0, out_valid}, 66'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R11 idle", {65'b0, out_valid}, 66'd0);
    // R2 ties to even
    run("R2 2.5",  64'h4004_0000_0000_0000, 1, 1, 0, 0, 0);
    run("R2 3.5",  64'h400C_0000_0000_0000, 1, 1, 0, 0, 0);
    run("R2 -2.5", 64'hC004_0000_0000_0000, 1, 0, 1, 0, 3);
    run("R2 0.5",  64'h3FE0_0000_0000_0000, 1, 1, 1, 0, 2);
    // R3 truncation
    run("R3 -3.75", 64'hC00E_0000_0000_0000, 1, 1, 1, 1, 0);
    // R4 up and down
    run("R4 up -0.5",  64'hBFE0_0000_0000_0000, 1, 1, 1, 2, 0);
    run("R4 down -0.5",64'hBFE0_0000_0000_0000, 1, 1, 1, 3, 0);
    run("R4 up 1.25",  32'h3FA0_0000, 0, 0, 0, 0, 2);
    run("R4 up subnormal", 64'h0000_0000_0000_0001, 1, 1, 1, 2, 0);
    // R5 explicit overrides control and vice versa
    run("R5 explicit zero", 64'h400C_0000_0000_0000, 1, 1, 1, 1, 2);
    run("R5 ctrl up",       64'h400C_0000_0000_0000, 1, 1, 0, 1, 2);
    // R6 specials
    run("R6 NaN long",  64'h7FF8_0000_0000_0000, 1, 1, 0, 0, 0);
    run("R6 -inf word", 32'hFF80_0000, 0, 0, 0, 0, 0);
    // R7 range edges
    run("R7 -2^63 ok",   64'hC3E0_0000_0000_0000, 1, 1, 0, 0, 0);
    run("R7 +2^63 bad",  64'h43E0_0000_0000_0000, 1, 1, 0, 0, 0);
    run("R7 -2^31 ok",   64'hC1E0_0000_0000_0000, 1, 0, 0, 0, 0);
    run("R7 2^31-0.5 up",64'h41DF_FFFF_FFE0_0000, 1, 0, 1, 2, 0);
    run("R7 single -2^31", 32'hCF00_0000, 0, 0, 0, 1, 1);
    // R8 zeros and exact values
    run("R8 -0", 64'h8000_0000_0000_0000, 1, 1, 0, 2, 3);
    run("R8 exact 7", 32'h40E0_0000, 0, 1, 0, 0, 0);
    // R9 single source with junk upper bits
    run("R9 single", 64'hDEAD_BEEF_C0B0_0000, 0, 1, 0, 0, 0);
    // R10 negative word
    run("R10 -5 word", 64'hC014_0000_0000_0000, 1, 0, 0, 0, 0);
    // random mix: R2 R3 R4 R5 R7 R8 R9 R10
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] op; bit dbl, lng, expl; int k;
      dbl = $urandom_range(0, 1); lng = $urandom_range(0, 1);
      expl = $urandom_range(0, 1);
      k = $urandom_range(0, 19);
      op = {$urandom, $urandom};
      if (dbl) begin
        if (k == 0) op[62:52] = 11'h7FF;
        else if (k == 1) op[62:52] = 0;
        else op[62:52] = 11'(1013 + $urandom_range(0, 60));
        if (k == 2) op[40:0] = 0;
      end else begin
        op[63:32] = $urandom;
        if (k == 0) op[30:23] = 8'hFF;
        else if (k == 1) op[30:23] = 0;
        else op[30:23] = 8'(117 + $urandom_range(0, 50));
        if (k == 2) op[15:0] = 0;
      end
      run("R9 random", op, dbl, lng, expl, 2'($urandom), 2'($urandom));
    end
    // R1 back-to-back stream
    in_op = 64'h4008_0000_0000_0000; in_src_dbl = 1; in_dst_long = 1;
    in_rm_explicit = 0; ctrl_rm = 0; in_valid = 1;
    @(negedge clk); @(negedge clk);
    check("R1 stream first", {65'b0, out_valid}, 66'd1);
    in_valid = 0;
    @(negedge clk);
    check("R1 stream second", {out_invalid, out_inexact, out_int}, {2'b00, 64'd3});
    @(negedge clk);
    check("R1 stream end", {65'b0, out_valid}, 66'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule